// File: doc/BRIEF.md
# Programmable Integer Clock Divider

This block derives a slower clock from an input clock. The ratio is any integer from 1 to 16, chosen by a 4-bit code. A down-counter runs on the input clock. Each time it reaches zero it reloads a terminal value derived from the current code, and that reload starts a new output period.

Odd ratios still give a waveform with a duty cycle near one half. A second phase register is clocked on the falling edge of the input clock and is ORed with the rising-edge phase, so the high time is always exactly half the period measured in input half-cycles. A ratio of 1 cannot be built from the counter, so a mux routes the input clock straight to the output instead.

A new code is sampled only at a reload. The period already under way therefore always completes at its old length, and a ratio change never produces a runt pulse.

Top module: `prog_clk_divider`

## Requirements
- R1: The 4-bit code `ratio_code_i` selects ratio N. Codes 1 to 15 give N equal to the code, and code 0 gives N = 16.
- R2: For N of 2 or more, the output period is exactly N input clock cycles, which is 2N input half-cycles between rising edges.
- R3: The internal down-counter loads N-1 on the edge after it reads zero, and otherwise decrements by one.
- R4: In every period the output is high for exactly N input half-cycles. For even N that is N/2 whole cycles. For odd N it is (N-1)/2 cycles plus one half-cycle, ending on a falling input edge.
- R5: For N = 1 the output follows the input clock level through a bypass mux.
- R6: A code change takes effect only at the next counter reload. The period in progress keeps its old high time and its old low time.
- R7: While the asynchronous reset `rst_i` is high, the output is low whatever the code is. Reset clears the counter to zero and sets the active ratio to 1, so the first edge after release performs a reload.
- R8: The counter never holds a value above N-1 for the active ratio N, and the active ratio always lies between 1 and 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Asynchronous reset, active high |
| ratio_code_i | input | 4 | Divide code; 0 means 16 |
| clk_o | output | 1 | Divided clock, or the input clock when N = 1 |

## Verification
On every cycle, the assertions check the counter's bound, its reload-to-N-1 step and its plain decrement. They also check that the active ratio holds steady between reloads and that the rising-edge phase is low in the last cycle of each period. Whole-waveform properties can only be shown by the bench's scenarios, which sample the output twice per input cycle. These are the period and the high time counted in half-cycles for each ratio, the bypass path tracking the input clock, the output held low under reset, and a ratio change mid-period that must leave the running period untouched.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
   typedef enum logic {
      PATH_DIVIDED = 1'b0,
      PATH_BYPASS  = 1'b1
   } path_sel_e;
endpackage

// File: rtl/clkdiv_ratio_dec.sv
`timescale 1ns/1ps
module clkdiv_ratio_dec #(
   parameter int CFG_W = 4,
   localparam int RW = CFG_W + 1,
   localparam int MAX_RATIO = 1 << CFG_W
) (
   input  logic [CFG_W-1:0] code_i,
   output logic [RW-1:0]    ratio_o
);
   // code 0 stands for the largest ratio
   always_comb begin
      if (code_i == '0) ratio_o = RW'(MAX_RATIO);
      else              ratio_o = {1'b0, code_i};
   end

   always_comb begin
      a_r1_ratio_range: assert (ratio_o >= RW'(1) && ratio_o <= RW'(MAX_RATIO))
         else $error("decoded ratio out of range");
   end
endmodule

// File: rtl/clkdiv_counter.sv
`timescale 1ns/1ps
module clkdiv_counter #(
   parameter int CFG_W = 4,
   localparam int RW = CFG_W + 1,
   localparam int MAX_RATIO = 1 << CFG_W
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [RW-1:0]    ratio_i,
   output logic [CFG_W-1:0] cnt_o,
   output logic [RW-1:0]    active_o,
   output logic             phase_o
);
   logic [RW-1:0] pos_next;
   logic          reload;

   assign reload   = (cnt_o == '0);
   // position inside the period once this edge has been taken
   assign pos_next = active_o - {1'b0, cnt_o};

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         cnt_o    <= '0;
         active_o <= RW'(1);
         phase_o  <= 1'b0;
      end else if (reload) begin
         cnt_o    <= CFG_W'(ratio_i - RW'(1));
         active_o <= ratio_i;
         phase_o  <= (ratio_i >= RW'(2));
      end else begin
         cnt_o    <= cnt_o - CFG_W'(1);
         phase_o  <= (pos_next < (active_o >> 1));
      end
   end

   a_r8_cnt_bound: assert property (@(posedge clk_i) disable iff (rst_i)
      ({1'b0, cnt_o} <= active_o - RW'(1)));

   a_r8_active_range: assert property (@(posedge clk_i) disable iff (rst_i)
      (active_o >= RW'(1) && active_o <= RW'(MAX_RATIO)));

   a_r3_reload: assert property (@(posedge clk_i) disable iff (rst_i)
      (cnt_o == '0) |=> ({1'b0, cnt_o} == active_o - RW'(1)));

   a_r3_decrement: assert property (@(posedge clk_i) disable iff (rst_i)
      (cnt_o != '0) |=> (cnt_o == $past(cnt_o) - CFG_W'(1)));

   a_r6_ratio_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      (cnt_o != '0) |=> $stable(active_o));

   a_r4_phase_low_at_end: assert property (@(posedge clk_i) disable iff (rst_i)
      (cnt_o == '0 && active_o > RW'(1)) |-> !phase_o);
endmodule

// File: rtl/clkdiv_halfphase.sv
`timescale 1ns/1ps
module clkdiv_halfphase (
   input  logic clk_i,
   input  logic rst_i,
   input  logic d_i,
   output logic q_o
);
   // retimes the rising-edge phase by half an input cycle
   always_ff @(negedge clk_i or posedge rst_i) begin
      if (rst_i) q_o <= 1'b0;
      else       q_o <= d_i;
   end
endmodule

// File: rtl/prog_clk_divider.sv
`timescale 1ns/1ps
module prog_clk_divider #(
   parameter int CFG_W = 4,
   parameter bit ODD_BALANCE = 1'b1,
   localparam int RW = CFG_W + 1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [CFG_W-1:0] ratio_code_i,
   output logic             clk_o
);
   import clkdiv_pkg::*;

   if (CFG_W < 1 || CFG_W > 8) begin : g_bad_cfg
      initial $error("CFG_W must lie in 1..8");
   end

   logic [RW-1:0]    ratio;
   logic [RW-1:0]    active;
   logic [CFG_W-1:0] cnt;
   logic             phase_rise;
   logic             phase_fall;
   logic             divided;
   path_sel_e        path;

   clkdiv_ratio_dec #(.CFG_W(CFG_W)) u_dec (
      .code_i  (ratio_code_i),
      .ratio_o (ratio)
   );

   clkdiv_counter #(.CFG_W(CFG_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .ratio_i  (ratio),
      .cnt_o    (cnt),
      .active_o (active),
      .phase_o  (phase_rise)
   );

   if (ODD_BALANCE) begin : g_half
      logic fall_q;
      clkdiv_halfphase u_half (
         .clk_i (clk_i),
         .rst_i (rst_i),
         .d_i   (phase_rise),
         .q_o   (fall_q)
      );
      assign phase_fall = fall_q & active[0];
   end else begin : g_nohalf
      assign phase_fall = 1'b0;
   end

   assign divided = phase_rise | phase_fall;
   assign path    = (active == RW'(1)) ? PATH_BYPASS : PATH_DIVIDED;

   always_comb begin
      if (rst_i)                     clk_o = 1'b0;
      else if (path == PATH_BYPASS)  clk_o = clk_i;
      else                           clk_o = divided;
   end
endmodule

// File: tb/test_prog_clk_divider.sv
`timescale 1ns/1ps
module test_prog_clk_divider;
   logic       clk;
   logic       rst;
   logic [3:0] code;
   logic       clk_out;

   int n_chk  = 0;
   int n_fail = 0;

   prog_clk_divider i_prog_clk_divider (
      .clk_i        (clk),
      .rst_i        (rst),
      .ratio_code_i (code),
      .clk_o        (clk_out)
   );

   initial clk = 1'b0;
   always #2.5 clk = ~clk;

   // {code[3:0], expected ratio[4:0]}
   localparam int NV = 10;
   localparam logic [8:0] VEC [NV] = '{
      {4'd1,  5'd1},  {4'd2,  5'd2},  {4'd3,  5'd3},  {4'd4,  5'd4},
      {4'd5,  5'd5},  {4'd7,  5'd7},  {4'd8,  5'd8},  {4'd11, 5'd11},
      {4'd15, 5'd15}, {4'd0,  5'd16}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one sample in the middle of each input half-cycle
   task automatic slot(output logic v);
      @(clk);
      #1.25;
      v = clk_out;
   endtask

   task automatic measure(input int n, input string tag);
      int   rises [4];
      int   nr = 0;
      int   hi = 0;
      logic prev, cur;
      slot(prev);
      for (int i = 1; i < 400 && nr < 4; i++) begin
         slot(cur);
         if (!prev && cur) begin
            rises[nr] = i;
            nr++;
         end
         if (cur && nr == 2) hi++;
         prev = cur;
      end
      if (nr < 4) begin
         check(1'b0, {tag, " R2 R3 R8 period (edges missing)"}, nr, 4);
         check(1'b0, {tag, " R4 high time (edges missing)"}, nr, 4);
      end else begin
         check((rises[2] - rises[1] == 2*n) && (rises[3] - rises[2] == 2*n),
               {tag, " R2 R3 R8 period in half-cycles"}, rises[3] - rises[2], 2*n);
         check(hi == n, {tag, " R4 high half-cycles"}, hi, n);
      end
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail);
      $finish;
   end

   initial begin
      logic v;
      int   bad;
      rst  = 1'b1;
      code = 4'd1;
      // R7: output low in reset, even with the bypass code applied
      bad = 0;
      for (int i = 0; i < 8; i++) begin
         slot(v);
         if (v !== 1'b0) bad++;
      end
      check(bad == 0, "R7 output low during reset", bad, 0);
      code = 4'd3;
      bad = 0;
      for (int i = 0; i < 6; i++) begin
         slot(v);
         if (v !== 1'b0) bad++;
      end
      check(bad == 0, "R7 output low during reset, code 3", bad, 0);
      code = 4'd1;
      rst  = 1'b0;
      // R5: bypass follows the input clock level
      bad = 0;
      for (int i = 0; i < 8; i++) begin
         slot(v);
         if (v !== clk) bad++;
      end
      check(bad == 0, "R5 bypass tracks input clock", bad, 0);

      // R1 table walk: each code gives its ratio
      for (int k = 0; k < NV; k++) begin
         code = VEC[k][8:5];
         measure(int'(VEC[k][4:0]), $sformatf("R1 code %0d", VEC[k][8:5]));
      end

      // R6: change mid-period, running period keeps old length
      code = 4'd8;
      measure(8, "R6 setup ratio 8");
      slot(v);
      while (v !== 1'b0) slot(v);
      while (v !== 1'b1) slot(v);
      begin
         int hi = 1;
         int lo = 0;
         slot(v); if (v) hi++;
         slot(v); if (v) hi++;
         code = 4'd2;
         slot(v);
         while (v === 1'b1) begin hi++; slot(v); end
         while (v === 1'b0) begin lo++; slot(v); end
         check(hi == 8, "R6 running period high time kept", hi, 8);
         check(lo == 8, "R6 running period low time kept", lo, 8);
      end
      measure(2, "R6 new ratio after reload");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule